// File: doc/BRIEF.md
# Bus Hold Handoff Controller

This block lets an external agent take over the system bus and later hands the bus back. A bus sequencer reports which bus state it is in and whether that state closes the current cycle. The controller looks at the hold-request input only in states where a handoff is allowed: an idle state, or the closing state of a bus cycle. When it sees a request there, it raises hold-acknowledge on the next rising clock edge.

One clock after acknowledge rises, the controller drops the output enables for the data, byte-enable, status and read/write pads. The pads stay floated until the requester withdraws its request. At that point acknowledge falls, the enables return, and the local side takes the bus back.

A bus-size strap selects 32-bit or 16-bit operation. The strap is captured once, on the first rising clock after reset is released. It decides which closing states count as handoff points. In 16-bit mode the strap also keeps the upper half of the data bus floated permanently.

Top module: `bus_hold_ctrl`

## Requirements
- R1: While reset is asserted and right after it: `hold_ack` is 0, `own_bus` is 1, `oe_ctl` and `oe_dlo` are 1, and `mode16` is 0.
- R2: `mode16` takes the value of `size16_strap` on the first rising clock edge after `rst_n` goes high.
- R3: Changes to `size16_strap` after that first edge have no effect on `mode16` or on `oe_dhi`.
- R4: In 32-bit mode a request is accepted only in three cases: `bus_state` is Ti (3'd0); `bus_state` is Ts (3'd1) with `last_st`=1; or `bus_state` is Tb4 (3'd2) with `last_st`=1. Tb8 (3'd3), Tw2 (3'd4), any other code, and closing states without `last_st` are never handoff points.
- R5: In 16-bit mode a request is accepted only in these cases: Ti; or Ts, Tb8 or Tw2 with `last_st`=1. Tb4 is not a handoff point in this mode.
- R6: A request accepted at a handoff point sets `hold_ack` on that same rising edge, so it is visible after the edge. `hold_ack` changes only on rising clock edges.
- R7: `oe_ctl` and `oe_dlo` go to 0 on the edge after `hold_ack` rises, and only if the request is still present. They stay 0 while `hold_ack` is 1 and are never 0 while `hold_ack` is 0.
- R8: While `hold_ack` is 1, a sampled `hold_req`=0 clears `hold_ack` and restores `oe_ctl` and `oe_dlo` to 1 on the same edge. This applies in any bus state.
- R9: In 16-bit mode `oe_dhi` is always 0. In 32-bit mode `oe_dhi` equals `oe_dlo`.
- R10: `own_bus` is always the inverse of `hold_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_state | input | 3 | Current bus state from the sequencer (Ti=0, Ts=1, Tb4=2, Tb8=3, Tw2=4, others=any other code) |
| last_st | input | 1 | High when the current state closes the bus cycle |
| hold_req | input | 1 | Request from an external agent to take the bus |
| size16_strap | input | 1 | Bus-size strap; 1 selects 16-bit operation |
| hold_ack | output | 1 | Grant of the bus to the external agent |
| own_bus | output | 1 | High while the local side holds mastership |
| oe_ctl | output | 1 | Output enable for byte-enable, status and read/write pads |
| oe_dlo | output | 1 | Output enable for data bits 15:0 |
| oe_dhi | output | 1 | Output enable for data bits 31:16 |
| mode16 | output | 1 | Latched bus-size mode |

## Verification
In 32-bit mode the request is held high through every bus state code, first with `last_st` low and then with it high. This separates the real handoff points from states that only have the right code, or only have the closing flag. The same walk in 16-bit mode shows that the handoff point moves away from Tb4 and to Tb8 and Tw2. Requests that are withdrawn one clock after the grant show that floating waits a clock and can be cancelled, unlike requests that are held. Strap toggles during and after reset distinguish the single capture edge from a level that is followed continuously.

// File: rtl/bus_hold_ctrl.sv
module bus_hold_ctrl #(
  parameter int ST_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] bus_state,
  input  logic            last_st,
  input  logic            hold_req,
  input  logic            size16_strap,
  output logic            hold_ack,
  output logic            own_bus,
  output logic            oe_ctl,
  output logic            oe_dlo,
  output logic            oe_dhi,
  output logic            mode16
);

  localparam logic [ST_W-1:0] S_TI  = ST_W'(0);
  localparam logic [ST_W-1:0] S_TS  = ST_W'(1);
  localparam logic [ST_W-1:0] S_TB4 = ST_W'(2);
  localparam logic [ST_W-1:0] S_TB8 = ST_W'(3);
  localparam logic [ST_W-1:0] S_TW2 = ST_W'(4);

  logic strap_done;
  logic ack_q, flt_q;
  logic close_pt, sample_pt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strap_done <= 1'b0;
      mode16     <= 1'b0;
    end else if (!strap_done) begin
      strap_done <= 1'b1;
      mode16     <= size16_strap;
    end
  end

  always_comb begin
    close_pt = 1'b0;
    if (last_st) begin
      if (bus_state == S_TS) close_pt = 1'b1;
      else if (mode16)       close_pt = (bus_state == S_TB8) || (bus_state == S_TW2);
      else                   close_pt = (bus_state == S_TB4);
    end
  end

  assign sample_pt = (bus_state == S_TI) || close_pt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      flt_q <= 1'b0;
    end else if (ack_q && !hold_req) begin
      ack_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      if (!ack_q && sample_pt && hold_req) ack_q <= 1'b1;
      flt_q <= ack_q;
    end
  end

  assign hold_ack = ack_q;
  assign own_bus  = ~ack_q;
  assign oe_ctl   = ~flt_q;
  assign oe_dlo   = ~flt_q;
  assign oe_dhi   = ~flt_q & ~mode16;

  a_r6_grant_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack && hold_req && sample_pt |=> hold_ack);

  a_r4_no_grant_off_point: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_ack && !(hold_req && (bus_state == S_TI ||
      (last_st && (bus_state == S_TS ||
        (mode16 ? (bus_state == S_TB8 || bus_state == S_TW2) : bus_state == S_TB4)))))
    |=> !hold_ack);

  a_r7_float_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) && hold_req |=> !oe_ctl && !oe_dlo);

  a_r7_float_only_held: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_ctl |-> hold_ack);

  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack && !hold_req |=> !hold_ack && oe_ctl && oe_dlo);

  a_r3_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> $stable(mode16));

  a_r9_upper_float: assert property (@(posedge clk) disable iff (!rst_n)
    mode16 |-> !oe_dhi);

  a_r10_own_inverse: assert property (@(posedge clk) own_bus != hold_ack);

endmodule

// File: tb/bus_hold_ctrl_tb.sv
module bus_hold_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_state = 3'd0;
  logic last_st = 1'b0, hold_req = 1'b0, size16_strap = 1'b0;
  logic hold_ack, own_bus, oe_ctl, oe_dlo, oe_dhi, mode16;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  bus_hold_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_state(bus_state), .last_st(last_st),
    .hold_req(hold_req), .size16_strap(size16_strap), .hold_ack(hold_ack),
    .own_bus(own_bus), .oe_ctl(oe_ctl), .oe_dlo(oe_dlo), .oe_dhi(oe_dhi),
    .mode16(mode16)
  );

  // {state[2:0], last, req, exp_ack, exp_oe} for 32-bit mode (R4, R6, R7, R8)
  localparam int NV = 15;
  localparam logic [6:0] VEC [NV] = '{
    {3'd1, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd2, 1'b0, 1'b1, 1'b0, 1'b1},
    {3'd3, 1'b1, 1'b1, 1'b0, 1'b1},
    {3'd4, 1'b1, 1'b1, 1'b0, 1'b1},
    {3'd7, 1'b1, 1'b1, 1'b0, 1'b1},
    {3'd2, 1'b1, 1'b0, 1'b0, 1'b1},
    {3'd2, 1'b1, 1'b1, 1'b1, 1'b1},
    {3'd7, 1'b0, 1'b1, 1'b1, 1'b0},
    {3'd0, 1'b0, 1'b1, 1'b1, 1'b0},
    {3'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'd0, 1'b0, 1'b1, 1'b1, 1'b1},
    {3'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'd1, 1'b1, 1'b1, 1'b1, 1'b1},
    {3'd0, 1'b0, 1'b1, 1'b1, 1'b0},
    {3'd0, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [2:0] st, input logic l, input logic r);
    @(negedge clk);
    bus_state = st; last_st = l; hold_req = r;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; size16_strap = strap; hold_req = 1'b0;
    bus_state = 3'd7; last_st = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 mode16 in reset", mode16, 1'b0);
    chk("R1 ack in reset", hold_ack, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    chk("R1 ack", hold_ack, 1'b0);
    chk("R10 own_bus", own_bus, 1'b1);
    chk("R1 oe_ctl", oe_ctl, 1'b1);
    chk("R1 oe_dlo", oe_dlo, 1'b1);
    chk("R2 mode16 32", mode16, 1'b0);
    @(negedge clk) size16_strap = 1'b1;
    step(3'd7, 1'b0, 1'b0);
    chk("R3 mode16 ignored", mode16, 1'b0);
    chk("R3 oe_dhi", oe_dhi, 1'b1);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][6:4], VEC[i][3], VEC[i][2]);
      chk("R4/R6/R8 ack", hold_ack, VEC[i][1]);
      chk("R7 oe_ctl", oe_ctl, VEC[i][0]);
      chk("R7 oe_dlo", oe_dlo, VEC[i][0]);
      chk("R9 oe_dhi 32", oe_dhi, VEC[i][0]);
      chk("R10 own_bus", own_bus, ~VEC[i][1]);
    end

    // 16-bit mode: strap latched on first edge, then withdrawn
    do_reset(1'b1);
    chk("R2 mode16 16", mode16, 1'b1);
    @(negedge clk) size16_strap = 1'b0;
    step(3'd2, 1'b1, 1'b1);
    chk("R3 mode16 held", mode16, 1'b1);
    chk("R5 Tb4 not point", hold_ack, 1'b0);
    chk("R9 oe_dhi 16", oe_dhi, 1'b0);
    step(3'd3, 1'b0, 1'b1);
    chk("R5 Tb8 needs last", hold_ack, 1'b0);
    step(3'd3, 1'b1, 1'b1);
    chk("R5 Tb8 grant", hold_ack, 1'b1);
    step(3'd0, 1'b0, 1'b1);
    chk("R7 float 16", oe_dlo, 1'b0);
    chk("R9 dhi floated", oe_dhi, 1'b0);
    step(3'd4, 1'b1, 1'b0);
    chk("R8 release any state", hold_ack, 1'b0);
    chk("R8 oe back", oe_ctl, 1'b1);
    chk("R9 dhi stays off", oe_dhi, 1'b0);
    step(3'd4, 1'b1, 1'b1);
    chk("R5 Tw2 grant", hold_ack, 1'b1);
    step(3'd7, 1'b0, 1'b0);
    chk("R8 early withdraw", hold_ack, 1'b0);
    chk("R7 never floated", oe_ctl, 1'b1);
    step(3'd1, 1'b1, 1'b1);
    chk("R5 Ts grant", hold_ack, 1'b1);
    step(3'd0, 1'b0, 1'b0);
    chk("R8 release 16", hold_ack, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule